// File: doc/BRIEF.md
# LiDAR Range Image Projection Engine

This block turns a stream of LiDAR returns, each given as azimuth, elevation and range, into a range image held in on-chip memory. Each return is mapped to a column from its azimuth and to a row from its elevation. Its range is then written into the pixel at that column and row. The image has a fixed size, with a power-of-two column count and a power-of-two row count chosen for the sensor when the block is built. Returns that land on an occupied pixel replace the older value. No interpolation takes place.

Points enter through a valid/ready stream that carries an end-of-frame flag. Before each frame the block clears every pixel to zero, which marks the pixel as empty, and it holds the input stalled while it does so. The frame ends when the flagged point has been accepted and has passed through the pipeline. The finished image is then streamed out of a valid/ready readout port in row-major order. Two counters report how many points were rejected and how many overwrote a filled pixel in the current frame.

Angles use binary-angle fixed point. The azimuth is a signed ANG_W-bit value `a`, with θ/π = a / 2^(ANG_W-1). The elevation is a signed ANG_W-bit value in the same units. Its field of view is bounded by the parameters EL_UP (top) and EL_DN (bottom).

Top module: `range_image_builder`

## Requirements
- R1: The column is ⌊((a + 2^(ANG_W-1))·(COLS−1) + 2^(ANG_W-1)) / 2^ANG_W⌋, the nearest integer (ties upward) to ½·(1+θ/π)·(COLS−1). A value of a = −2^(ANG_W-1) gives column 0, and a = 0 gives column COLS/2 for the default 16 columns.
- R2: The row is the nearest integer (ties upward) to (EL_UP − e)·(ROWS−1)/(EL_UP − EL_DN). e = EL_UP gives row 0 and e = EL_DN gives row ROWS−1.
- R3: Pixel index = row·COLS + column. Readout delivers pixel indices 0 to COLS·ROWS−1 in ascending order, and `out_last` is high only with the final pixel.
- R4: A point whose elevation lies above EL_UP or below EL_DN, or whose range is zero, writes no pixel and increments `drop_count` by one.
- R5: When a point lands on a pixel already written in the same frame, the later range replaces the earlier one and `collision_count` increments by one.
- R6: After reset and after every readout, all pixels are set to zero before a new frame. `in_ready` stays low for at least COLS·ROWS cycles during this clear.
- R7: While a frame is being filled, `in_ready` stays high, so one point is accepted every cycle up to the end-of-frame point.
- R8: Accepting a point with `in_last` high ends the frame, even when that point is dropped. `in_ready` is low in the following cycle, and readout begins only after every accepted point has been written.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. Readout advances one pixel per handshake.
- R10: Both counters are zero at the start of each frame and hold their values throughout readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Point present |
| in_ready | output | 1 | Block accepts a point |
| in_azimuth | input | ANG_W | Signed azimuth, binary angle |
| in_elevation | input | ANG_W | Signed elevation, same units as EL_UP/EL_DN |
| in_range | input | RNG_W | Range value, zero means no return |
| in_last | input | 1 | Point is the last of the frame |
| out_valid | output | 1 | Readout pixel present |
| out_ready | input | 1 | Consumer takes the pixel |
| out_data | output | RNG_W | Stored range of the pixel |
| out_last | output | 1 | Final pixel of the image |
| drop_count | output | CNT_W | Points rejected this frame |
| collision_count | output | CNT_W | Points that overwrote a pixel this frame |

## Verification
If a pixel is missed by the clear, or an address is formed wrongly, the fault shows up only in the readout stream. A stale or misplaced range then appears at a specific pixel index one frame later. For this reason every frame is compared pixel by pixel against an arithmetic model, after both a dense sweep and a set of boundary points. A wrong occupancy bit or a wrong drop decision shows up in the two counters as soon as readout starts. A stuck state or a pipeline that never drains shows as `in_ready` or `out_valid` failing to change within a bounded number of cycles.

// File: rtl/ri_pkg.sv
package ri_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_READ  = 2'd3
    } ri_state_e;
endpackage

// File: rtl/ri_col_map.sv
module ri_col_map #(
    parameter int ANG_W = 16,
    parameter int COLS  = 16
) (
    input  logic signed [ANG_W-1:0]   azimuth,
    output logic [$clog2(COLS)-1:0]   col
);
    localparam int COL_W = $clog2(COLS);
    localparam int PW    = ANG_W + COL_W + 2;

    logic [PW-1:0] biased;
    logic [PW-1:0] scaled;

    always_comb begin
        // offset binary equals azimuth + half turn, never negative
        biased = PW'({~azimuth[ANG_W-1], azimuth[ANG_W-2:0]});
        scaled = biased * PW'(COLS - 1) + (PW'(1) << (ANG_W - 1));
        col    = COL_W'(scaled >> ANG_W);
    end
endmodule

// File: rtl/ri_row_map.sv
module ri_row_map #(
    parameter int ANG_W = 16,
    parameter int ROWS  = 8,
    parameter int EL_UP = 4096,
    parameter int EL_DN = -4096
) (
    input  logic signed [ANG_W-1:0]   elevation,
    output logic [$clog2(ROWS)-1:0]   row,
    output logic                      outside
);
    localparam int          ROW_W = $clog2(ROWS);
    localparam int          FRAC  = ANG_W + 8;
    localparam logic [63:0] RECIP = (64'(ROWS - 1) << FRAC) / 64'(EL_UP - EL_DN);

    logic [31:0] below_top;
    logic [63:0] scaled;

    always_comb begin
        outside   = (int'(elevation) > EL_UP) || (int'(elevation) < EL_DN);
        below_top = 32'(EL_UP - int'(elevation));
        scaled    = {32'd0, below_top} * RECIP + (64'd1 << (FRAC - 1));
        row       = ROW_W'(scaled >> FRAC);
    end
endmodule

// File: rtl/ri_pixel_ram.sv
module ri_pixel_ram #(
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          mark,
    output logic          hit,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] occ;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
            occ[waddr] <= mark;
        end
    end

    assign hit   = occ[waddr];
    assign rdata = mem[raddr];
endmodule

// File: rtl/range_image_builder.sv
module range_image_builder
    import ri_pkg::*;
#(
    parameter int COLS  = 16,
    parameter int ROWS  = 8,
    parameter int ANG_W = 16,
    parameter int RNG_W = 16,
    parameter int CNT_W = 16,
    parameter int EL_UP = 4096,
    parameter int EL_DN = -4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [ANG_W-1:0] in_azimuth,
    input  logic signed [ANG_W-1:0] in_elevation,
    input  logic [RNG_W-1:0]        in_range,
    input  logic                    in_last,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [RNG_W-1:0]        out_data,
    output logic                    out_last,
    output logic [CNT_W-1:0]        drop_count,
    output logic [CNT_W-1:0]        collision_count
);
    localparam int COL_W  = $clog2(COLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int ADDR_W = COL_W + ROW_W;
    localparam int PIX    = COLS * ROWS;
    localparam logic [ADDR_W-1:0] LAST_PIX = ADDR_W'(PIX - 1);

    typedef struct packed {
        ri_state_e                st;
        logic [ADDR_W-1:0]        ptr;
        logic                     s1_vld;
        logic signed [ANG_W-1:0]  s1_az;
        logic signed [ANG_W-1:0]  s1_el;
        logic [RNG_W-1:0]         s1_rng;
        logic                     s1_last;
        logic                     s2_wr;
        logic                     s2_last;
        logic [ADDR_W-1:0]        s2_addr;
        logic [RNG_W-1:0]         s2_rng;
        logic [CNT_W-1:0]         drops;
        logic [CNT_W-1:0]         colls;
    } regs_t;

    regs_t q, d;

    logic [COL_W-1:0]  col_idx;
    logic [ROW_W-1:0]  row_idx;
    logic              el_outside;
    logic              clearing;
    logic              accept;
    logic              reject;
    logic              ram_we;
    logic              ram_mark;
    logic              ram_hit;
    logic [ADDR_W-1:0] ram_waddr;
    logic [RNG_W-1:0]  ram_wdata;
    logic [RNG_W-1:0]  ram_rdata;

    ri_col_map #(.ANG_W(ANG_W), .COLS(COLS)) u_col (
        .azimuth (q.s1_az),
        .col     (col_idx)
    );

    ri_row_map #(.ANG_W(ANG_W), .ROWS(ROWS), .EL_UP(EL_UP), .EL_DN(EL_DN)) u_row (
        .elevation (q.s1_el),
        .row       (row_idx),
        .outside   (el_outside)
    );

    assign clearing  = (q.st == ST_CLEAR);
    assign ram_we    = clearing || q.s2_wr;
    assign ram_waddr = clearing ? q.ptr : q.s2_addr;
    assign ram_wdata = clearing ? '0 : q.s2_rng;
    assign ram_mark  = !clearing;

    ri_pixel_ram #(.DEPTH(PIX), .AW(ADDR_W), .DW(RNG_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .mark  (ram_mark),
        .hit   (ram_hit),
        .raddr (q.ptr),
        .rdata (ram_rdata)
    );

    assign in_ready        = (q.st == ST_FILL);
    assign accept          = in_valid && in_ready;
    assign reject          = q.s1_vld && (el_outside || (q.s1_rng == '0));
    assign out_valid       = (q.st == ST_READ);
    assign out_data        = ram_rdata;
    assign out_last        = out_valid && (q.ptr == LAST_PIX);
    assign drop_count      = q.drops;
    assign collision_count = q.colls;

    always_comb begin
        d = q;
        // stage 1: capture the raw point
        d.s1_vld  = accept;
        d.s1_last = accept && in_last;
        if (accept) begin
            d.s1_az  = in_azimuth;
            d.s1_el  = in_elevation;
            d.s1_rng = in_range;
        end
        // stage 2: mapped address, write happens from here
        d.s2_wr   = q.s1_vld && !reject;
        d.s2_last = q.s1_vld && q.s1_last;
        d.s2_addr = {row_idx, col_idx};
        d.s2_rng  = q.s1_rng;
        if (reject) begin
            d.drops = q.drops + 1'b1;
        end
        if (q.s2_wr && ram_hit) begin
            d.colls = q.colls + 1'b1;
        end
        unique case (q.st)
            ST_CLEAR: begin
                d.ptr   = q.ptr + 1'b1;
                d.drops = '0;
                d.colls = '0;
                if (q.ptr == LAST_PIX) begin
                    d.st  = ST_FILL;
                    d.ptr = '0;
                end
            end
            ST_FILL: begin
                if (accept && in_last) begin
                    d.st = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (q.s2_last) begin
                    d.st  = ST_READ;
                    d.ptr = '0;
                end
            end
            ST_READ: begin
                if (out_ready) begin
                    d.ptr = q.ptr + 1'b1;
                    if (q.ptr == LAST_PIX) begin
                        d.st  = ST_CLEAR;
                        d.ptr = '0;
                    end
                end
            end
            default: d.st = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_CLEAR;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ri_proj_chk.sv
module ri_proj_chk #(
    parameter int RNG_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RNG_W-1:0] out_data,
    input logic             out_last,
    input logic [CNT_W-1:0] drop_count,
    input logic [CNT_W-1:0] collision_count
);
    // R6
    in_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8
    last_stops_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);

    // R9
    readout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R10
    counters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> ($stable(drop_count) && $stable(collision_count)));

    // R3
    last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

bind range_image_builder ri_proj_chk #(.RNG_W(RNG_W), .CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_last         (in_last),
    .out_valid       (out_valid),
    .out_ready       (out_ready),
    .out_data        (out_data),
    .out_last        (out_last),
    .drop_count      (drop_count),
    .collision_count (collision_count)
);

// File: tb/tb_range_image_builder.sv
`timescale 1ns/1ps
module tb_range_image_builder;
    localparam int COLS = 16;
    localparam int ROWS = 8;
    localparam int PIX  = COLS * ROWS;
    localparam int UP   = 4096;
    localparam int DN   = -4096;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_azimuth = '0;
    logic signed [15:0] in_elevation = '0;
    logic [15:0]        in_range = '0;
    logic               in_last = 1'b0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic [15:0]        out_data;
    logic               out_last;
    logic [15:0]        drop_count;
    logic [15:0]        collision_count;

    int compared = 0;
    int mismatched = 0;
    int exp_img [PIX];
    bit occ [PIX];
    int exp_drops;
    int exp_colls;
    int stalls;
    bit started;

    always #2.5 clk = ~clk;

    range_image_builder dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_azimuth(in_azimuth), .in_elevation(in_elevation),
        .in_range(in_range), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last),
        .drop_count(drop_count), .collision_count(collision_count)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < PIX; i++) begin
            exp_img[i] = 0;
            occ[i] = 1'b0;
        end
        exp_drops = 0;
        exp_colls = 0;
        stalls = 0;
        started = 1'b0;
    endtask

    task automatic model_point(input int az, input int el, input int rng);
        int u;
        int v;
        int a;
        if (rng == 0 || el > UP || el < DN) begin
            exp_drops++;
        end else begin
            u = ((az + 32768) * (COLS - 1) + 32768) >>> 16;
            v = ((UP - el) * (ROWS - 1) + (UP - DN) / 2) / (UP - DN);
            a = v * COLS + u;
            if (occ[a]) exp_colls++;
            occ[a] = 1'b1;
            exp_img[a] = rng;
        end
    endtask

    task automatic send(input int az, input int el, input int rng, input bit last);
        @(negedge clk);
        in_valid     = 1'b1;
        in_azimuth   = 16'(az);
        in_elevation = 16'(el);
        in_range     = 16'(rng);
        in_last      = last;
        while (!in_ready) begin
            if (started) stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        started = 1'b1;
        model_point(az, el, rng);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        @(negedge clk);
        while (!in_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic readout(input string tag);
        int idx = 0;
        int cyc = 0;
        @(negedge clk);
        while (!out_valid && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        // R10 counters at readout start, R4 drops, R5 collisions
        check({tag, " R4 drop_count"}, drop_count, exp_drops);
        check({tag, " R5 collision_count"}, collision_count, exp_colls);
        while (idx < PIX && cyc < 4000) begin
            out_ready = ((idx + cyc) % 3) != 1;
            #0.5;
            if (out_valid && out_ready) begin
                // R3 R9 pixel order and data, R1 R2 mapping via model
                check({tag, " R3 pixel data"}, out_data, exp_img[idx]);
                check({tag, " R3 out_last"}, out_last, idx == PIX - 1);
                idx++;
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        check({tag, " R9 all pixels delivered"}, idx, PIX);
    endtask

    initial begin
        int n;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check("R6 in_ready after reset", in_ready, 0);
        check("R3 out_valid after reset", out_valid, 0);
        n = 1;
        while (!in_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        // R6 clear lasts at least PIX cycles
        check("R6 clear length lower bound", n >= PIX, 1);
        check("R6 clear length upper bound", n <= PIX + 2, 1);

        // frame 1: dense sweep with out-of-range elevations and zero ranges
        for (int k = 0; k < 300; k++) begin
            send(-32768 + k * 219, -4600 + (k * 37) % 9200,
                 (k % 23 == 0) ? 0 : k + 1, k == 299);
        end
        // R8 input closed after last
        @(negedge clk);
        check("R8 in_ready low after last", in_ready, 0);
        // R7 no stall during fill
        check("R7 stall cycles", stalls, 0);
        readout("frame1");

        // frame 2: boundaries; also proves clear (R6) since model starts at zero
        model_reset();
        wait_ready();
        send(-32768, UP, 11, 1'b0);   // R1 R2 column 0 row 0
        send(32767, DN, 22, 1'b0);    // R1 R2 last column last row
        send(0, 0, 33, 1'b0);         // R1 column 8, R2 row 4
        send(0, 0, 44, 1'b0);         // R5 collision, later wins
        send(100, UP + 1, 55, 1'b0);  // R4 above top
        send(100, DN - 1, 66, 1'b0);  // R4 below bottom
        send(5, 10, 0, 1'b0);         // R4 zero range
        send(0, 5000, 77, 1'b1);      // R8 dropped last still ends frame
        check("R1 R2 model pixel 72", exp_img[72], 44);
        readout("frame2");

        // frame 3: single point after second clear
        model_reset();
        wait_ready();
        send(16384, -2048, 99, 1'b1);
        readout("frame3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule